// File: doc/BRIEF.md
# Pin-change interrupt with bus alert response

This block watches a wide bank-organised set of general-purpose pins and raises an interrupt when any pin that is set up as an input, and not masked, moves away from its reference level. Each pin's reference is the level last handed to software by a read of that pin's bank of the input port. Reading a bank therefore re-arms the detection for its eight pins. A pin that returns to its reference level before any read stops requesting the interrupt by itself.

The interrupt is an open-drain, active-low line. The block only ever asks the pad to pull the line low and otherwise leaves it released, so several devices can share one wired-AND line. The same line serves as a shared SMBus-style alert. When the slave interface reports a read to the alert response address while this device is pulling the line, the block presents its own 7-bit address as the response byte and then releases the line. It pulls the line again only when a pin that was not already reported starts to differ.

Pin levels arrive asynchronously and pass through a two-flop synchroniser before comparison. For the first cycles after reset, the references are loaded from the synchronised levels, so whatever levels are present at start-up raise nothing.

Top module: `pinchg_alert`

## Requirements
- R1: A level change on a pin whose direction bit is 1 (input) and whose mask bit is 0 drives `irq_pull_low` to 1 on the third rising clock edge after the pin changes.
- R2: A pin whose mask bit is 1, or whose direction bit is 0 (output), never causes `irq_pull_low` to assert. Clearing the mask bit of a pin that already differs from its reference asserts `irq_pull_low` on the next rising edge.
- R3: `irq_pull_low` = 1 means the shared active-low line is pulled low, and 0 means it is released. The block never actively drives the line high.
- R4: A pulse on `port_rd_stb` with bank index `port_rd_bank` = b (pins 8b to 8b+7) loads that bank's references from the synchronised levels. Pending changes in bank b then release the line on the second rising edge after the strobe, while pending changes in other banks keep it pulled.
- R5: If every changed pin returns to its reference level before a read, `irq_pull_low` returns to 0 without any read.
- R6: A pulse on `ara_req` while `irq_pull_low` is 1 gives `ara_ack` = 1 for one cycle on the next edge, with `ara_data` = {`dev_addr`, 1'b0} (address in bits 7:1, bit 0 zero). With `irq_pull_low` at 0, `ara_req` gives no `ara_ack`. `ara_data` is zero whenever `ara_ack` is 0.
- R7: After an alert response, `irq_pull_low` drops on the second edge after `ara_req` and stays released for the pins already reported. A change on a pin that was not reported asserts it again.
- R8: After reset `irq_pull_low`, `ara_ack` and `ara_data` are 0, and pin levels present at reset release raise no interrupt.
- R9: A read strobe whose bank index is not below the number of banks (5 to 7 with defaults) changes no reference and leaves `irq_pull_low` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pin_lvl | input | 40 | Asynchronous pin levels |
| pin_is_in | input | 40 | Direction per pin, 1 = input |
| pin_masked | input | 40 | Interrupt mask per pin, 1 = masked |
| port_rd_stb | input | 1 | Input-port read of one bank, one-cycle pulse |
| port_rd_bank | input | 3 | Bank index of that read |
| dev_addr | input | 7 | This device's bus address |
| ara_req | input | 1 | Alert-response read request, one-cycle pulse |
| irq_pull_low | output | 1 | Open-drain enable: 1 pulls the shared line low |
| ara_ack | output | 1 | This device answers the alert response read |
| ara_data | output | 8 | Alert response byte |

## Verification
A pin change reaches `irq_pull_low` on the third rising edge after it is driven: two synchroniser edges, then the output register. A mask or direction change shows on the first edge. A read strobe or alert request acts on the edge that samples it and shows at the output one edge later, while `ara_ack` and `ara_data` appear on the first edge after the request. The bench drives stimulus on falling edges. It advances a behavioural model on each rising edge and compares every output a quarter period after that edge, so each expected value lands on the cycle counted above. Directed checks at those same offsets back up the scenario that each requirement covers.

// File: rtl/pinchg_pkg.sv
// Package: shared sizing for the pin-change alert block.
// Assumes pins are grouped in equal banks that are read one bank at a time.
package pinchg_pkg;
    localparam int BANK_W      = 8;
    localparam int NUM_BANKS   = 5;
    localparam int SYNC_STAGES = 2;
    localparam int ADDR_W      = 7;
endpackage

// File: rtl/pinchg_sync.sv
// Module: multi-stage level synchroniser for a vector of asynchronous pins.
// Assumes each bit is independent; no coherence between bits is implied.
module pinchg_sync #(
    parameter int W      = 40,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg_q;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        // shift the sampled levels one stage further each clock
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stg_q[s] <= '0;
            end else if (s == 0) begin
                stg_q[s] <= d;
            end else begin
                stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
            end
        end
    end

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/pinchg_bank_tracker.sv
// Module: holds one bank's reference levels and flags enabled pins that differ.
// Assumes lvl is already synchronised; capture loads the reference from lvl.
module pinchg_bank_tracker #(
    parameter int BANK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] lvl,
    input  logic [BANK_W-1:0] is_input,
    input  logic [BANK_W-1:0] masked,
    input  logic              capture,
    output logic [BANK_W-1:0] change
);
    logic [BANK_W-1:0] ref_q;

    // reload the reference on a bank read or during start-up priming
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q <= '0;
        end else if (capture) begin
            ref_q <= lvl;
        end
    end

    // a pin counts only if it is an input and unmasked
    always_comb begin
        change = (lvl ^ ref_q) & is_input & ~masked;
    end
endmodule

// File: rtl/pinchg_alert_ctrl.sv
// Module: drives the open-drain alert enable and answers alert response reads.
// Assumes ara_req is a one-cycle pulse; quiet holds the block silent at start-up.
module pinchg_alert_ctrl #(
    parameter int NPINS  = 40,
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPINS-1:0]  change,
    input  logic              quiet,
    input  logic              ara_req,
    input  logic [ADDR_W-1:0] dev_addr,
    output logic              pull_low,
    output logic              ara_ack,
    output logic [ADDR_W:0]   ara_data
);
    logic [NPINS-1:0] served_q;
    logic             pull_q;
    logic             answer;

    assign answer = ara_req && pull_q;

    // remember pins already reported; forget a pin once it stops differing
    always_ff @(posedge clk) begin
        if (!rst_n || quiet) begin
            served_q <= '0;
        end else if (answer) begin
            served_q <= change;
        end else begin
            served_q <= served_q & change;
        end
    end

    // pull the shared line while any unreported pin differs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pull_q <= 1'b0;
        end else begin
            pull_q <= !quiet && |(change & ~served_q);
        end
    end

    // present the address byte for one cycle when this device answers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ara_ack  <= 1'b0;
            ara_data <= '0;
        end else begin
            ara_ack  <= answer;
            ara_data <= answer ? {dev_addr, 1'b0} : '0;
        end
    end

    assign pull_low = pull_q;
endmodule

// File: rtl/pinchg_alert.sv
// Module: top of the pin-change interrupt with alert response.
// Assumes strobes are one-cycle pulses from the slave interface in this clock domain.
module pinchg_alert
    import pinchg_pkg::*;
#(
    parameter int BW     = BANK_W,
    parameter int NB     = NUM_BANKS,
    parameter int NSYNC  = SYNC_STAGES,
    parameter int AW     = ADDR_W,
    localparam int NPINS = BW * NB,
    localparam int BIX_W = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_lvl,
    input  logic [NPINS-1:0] pin_is_in,
    input  logic [NPINS-1:0] pin_masked,
    input  logic             port_rd_stb,
    input  logic [BIX_W-1:0] port_rd_bank,
    input  logic [AW-1:0]    dev_addr,
    input  logic             ara_req,
    output logic             irq_pull_low,
    output logic             ara_ack,
    output logic [AW:0]      ara_data
);
    localparam int PRIME_LIM = NSYNC + 1;
    localparam int CNT_W     = $clog2(PRIME_LIM + 1);
    localparam logic [CNT_W-1:0] PRIME_END = CNT_W'(PRIME_LIM);

    logic [NPINS-1:0] sync_lvl;
    logic [NPINS-1:0] change_vec;
    logic [CNT_W-1:0] prime_q;
    logic             quiet;

    pinchg_sync #(.W(NPINS), .STAGES(NSYNC)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_lvl),
        .q     (sync_lvl)
    );

    // count out the synchroniser fill before references become valid
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prime_q <= '0;
        end else if (prime_q != PRIME_END) begin
            prime_q <= prime_q + 1'b1;
        end
    end

    assign quiet = (prime_q != PRIME_END);

    for (genvar b = 0; b < NB; b++) begin : g_bank
        logic cap;
        assign cap = quiet || (port_rd_stb && (port_rd_bank == BIX_W'(b)));
        pinchg_bank_tracker #(.BANK_W(BW)) u_trk (
            .clk      (clk),
            .rst_n    (rst_n),
            .lvl      (sync_lvl[b*BW +: BW]),
            .is_input (pin_is_in[b*BW +: BW]),
            .masked   (pin_masked[b*BW +: BW]),
            .capture  (cap),
            .change   (change_vec[b*BW +: BW])
        );
    end

    pinchg_alert_ctrl #(.NPINS(NPINS), .ADDR_W(AW)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .change   (change_vec),
        .quiet    (quiet),
        .ara_req  (ara_req),
        .dev_addr (dev_addr),
        .pull_low (irq_pull_low),
        .ara_ack  (ara_ack),
        .ara_data (ara_data)
    );
endmodule

// File: rtl/pinchg_alert_chk.sv
// Module: property checker bound to the pin-change alert top.
// Assumes the same clock and synchronous reset as the design.
module pinchg_alert_chk #(
    parameter int NPINS = 40,
    parameter int AW    = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             quiet,
    input logic [NPINS-1:0] change_vec,
    input logic             irq_pull_low,
    input logic             ara_req,
    input logic             ara_ack,
    input logic [AW:0]      ara_data
);
    // R8: no pull while references are being primed
    p_quiet_at_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        quiet |=> !irq_pull_low);

    // R2: the line is only pulled after an enabled pin differed
    p_pull_has_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_pull_low) |-> $past(|change_vec));

    // R6: an answer needs a request while the line was pulled
    p_answer_needs_alert_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ara_ack |-> ($past(ara_req) && $past(irq_pull_low)));

    // R6: response byte is zero when not answering
    p_idle_byte_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ara_ack |-> (ara_data == '0));

    // R6: an answer lasts one cycle for a one-cycle request
    p_answer_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ara_ack && !ara_req) |=> !ara_ack);
endmodule

bind pinchg_alert pinchg_alert_chk #(.NPINS(NPINS), .AW(AW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .quiet        (quiet),
    .change_vec   (change_vec),
    .irq_pull_low (irq_pull_low),
    .ara_req      (ara_req),
    .ara_ack      (ara_ack),
    .ara_data     (ara_data)
);

// File: tb/pinchg_alert_tb_top.sv
// Bench: behavioural reference model compared with the outputs every clock,
// plus directed checks at the cycle each result is due.
module pinchg_alert_tb_top;
    localparam int CLK_P = 10;
    localparam int NP    = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pin_lvl = '0;
    logic [NP-1:0] pin_is_in = '0;
    logic [NP-1:0] pin_masked = '0;
    logic          port_rd_stb = 1'b0;
    logic [2:0]    port_rd_bank = '0;
    logic [6:0]    dev_addr = 7'h4B;
    logic          ara_req = 1'b0;
    logic          irq_pull_low;
    logic          ara_ack;
    logic [7:0]    ara_data;

    int    n_checks = 0;
    int    n_errors = 0;
    int    cyc = 0;
    bit    compare_on = 1'b0;
    string cur_req = "R8";

    pinchg_alert dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .pin_lvl      (pin_lvl),
        .pin_is_in    (pin_is_in),
        .pin_masked   (pin_masked),
        .port_rd_stb  (port_rd_stb),
        .port_rd_bank (port_rd_bank),
        .dev_addr     (dev_addr),
        .ara_req      (ara_req),
        .irq_pull_low (irq_pull_low),
        .ara_ack      (ara_ack),
        .ara_data     (ara_data)
    );

    always #(CLK_P/2) clk = ~clk;

    // reference model state
    logic [NP-1:0] m_s1, m_s2, m_ref, m_srv;
    bit            m_int, m_ack;
    logic [7:0]    m_data;
    int            m_age;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = '0; m_s2 = '0; m_ref = '0; m_srv = '0;
            m_int = 0; m_ack = 0; m_data = '0; m_age = 0;
        end else begin
            logic [NP-1:0] diff;
            bit            priming, n_ack;
            diff    = (m_s2 ^ m_ref) & pin_is_in & ~pin_masked;
            priming = (m_age < 3);
            n_ack   = ara_req && m_int;
            m_data  = n_ack ? {dev_addr, 1'b0} : 8'h00;
            m_int   = !priming && ((diff & ~m_srv) != '0);
            m_srv   = priming ? '0 : (n_ack ? diff : (m_srv & diff));
            m_ack   = n_ack;
            for (int i = 0; i < NP; i++) begin
                if (priming || (port_rd_stb && int'(port_rd_bank) == i / 8))
                    m_ref[i] = m_s2[i];
            end
            m_s2 = m_s1;
            m_s1 = pin_lvl;
            if (m_age < 3) m_age++;
        end
    end

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string what);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
        end
    endtask

    // compare every cycle, a quarter period after the rising edge
    always @(posedge clk) begin
        #(CLK_P/4);
        if (compare_on) begin
            chk({7'd0, irq_pull_low}, {7'd0, m_int}, "model irq");
            chk({7'd0, ara_ack}, {7'd0, m_ack}, "model ack");
            chk(ara_data, m_data, "model data");
        end
    end

    // watchdog: a hung run counts as a failure
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_errors++;
            $display("FAIL R1 watchdog: actual %0d cycles expected below 20000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    task automatic nedges(input int n);
        repeat (n) @(negedge clk);
    endtask

    // sample point: just after the rising edge following the current falling edge
    task automatic at_edge(input int n);
        repeat (n) @(posedge clk);
        #(CLK_P/4 + 1);
    endtask

    task automatic bank_read(input int b);
        @(negedge clk);
        port_rd_stb = 1'b1; port_rd_bank = 3'(b);
        @(negedge clk);
        port_rd_stb = 1'b0;
    endtask

    initial begin
        // R8: reset with pins already at non-zero levels
        pin_is_in = '1;
        pin_lvl   = 40'hA5_00_F0_00_3C;
        nedges(3);
        chk({7'd0, irq_pull_low}, 8'd0, "reset irq");
        chk({7'd0, ara_ack}, 8'd0, "reset ack");
        chk(ara_data, 8'd0, "reset data");
        rst_n = 1'b1;
        compare_on = 1'b1;
        nedges(8);
        chk({7'd0, irq_pull_low}, 8'd0, "start-up levels quiet");

        // R1: toggle pin 3 and watch the third edge
        cur_req = "R1";
        @(negedge clk);
        pin_lvl[3] = ~pin_lvl[3];
        at_edge(2);
        chk({7'd0, irq_pull_low}, 8'd0, "not yet at edge 2");
        at_edge(1);
        chk({7'd0, irq_pull_low}, 8'd1, "pulled at edge 3");

        // R4: read bank 0 releases on second edge after strobe
        cur_req = "R4";
        @(negedge clk);
        port_rd_stb = 1'b1; port_rd_bank = 3'd0;
        at_edge(1);
        chk({7'd0, irq_pull_low}, 8'd1, "still pulled edge 1");
        @(negedge clk);
        port_rd_stb = 1'b0;
        at_edge(1);
        chk({7'd0, irq_pull_low}, 8'd0, "released edge 2");

        // R4: changes in banks 2 and 4; reading bank 2 keeps the pull
        @(negedge clk);
        pin_lvl[17] = ~pin_lvl[17];
        pin_lvl[38] = ~pin_lvl[38];
        nedges(4);
        chk({7'd0, irq_pull_low}, 8'd1, "two banks pending");
        bank_read(2);
        nedges(2);
        chk({7'd0, irq_pull_low}, 8'd1, "bank 4 still pending");
        // R9: out-of-range bank indices change nothing
        cur_req = "R9";
        bank_read(5);
        bank_read(7);
        nedges(2);
        chk({7'd0, irq_pull_low}, 8'd1, "bad bank ignored");
        cur_req = "R4";
        bank_read(4);
        nedges(2);
        chk({7'd0, irq_pull_low}, 8'd0, "bank 4 read clears");

        // R5: change and change back without a read
        cur_req = "R5";
        @(negedge clk);
        pin_lvl[25] = ~pin_lvl[25];
        nedges(4);
        chk({7'd0, irq_pull_low}, 8'd1, "pulled after change");
        pin_lvl[25] = ~pin_lvl[25];
        nedges(4);
        chk({7'd0, irq_pull_low}, 8'd0, "released on return");

        // R2: masked pin and output pin stay silent; unmask shows next edge
        cur_req = "R2";
        @(negedge clk);
        pin_masked[9] = 1'b1;
        pin_is_in[30] = 1'b0;
        pin_lvl[9]  = ~pin_lvl[9];
        pin_lvl[30] = ~pin_lvl[30];
        nedges(6);
        chk({7'd0, irq_pull_low}, 8'd0, "masked and output silent");
        pin_masked[9] = 1'b0;
        at_edge(1);
        chk({7'd0, irq_pull_low}, 8'd1, "unmask asserts next edge");
        bank_read(1);
        bank_read(3);
        pin_is_in[30] = 1'b1;
        nedges(3);
        chk({7'd0, irq_pull_low}, 8'd0, "cleared after reads");

        // R6: no answer while the line is released
        cur_req = "R6";
        @(negedge clk);
        ara_req = 1'b1;
        at_edge(1);
        chk({7'd0, ara_ack}, 8'd0, "no answer when idle");
        @(negedge clk);
        ara_req = 1'b0;

        // R6 and R3: answer with the address byte while pulling low
        @(negedge clk);
        pin_lvl[12] = ~pin_lvl[12];
        nedges(4);
        cur_req = "R3";
        chk({7'd0, irq_pull_low}, 8'd1, "line pulled low");
        cur_req = "R6";
        ara_req = 1'b1;
        at_edge(1);
        chk({7'd0, ara_ack}, 8'd1, "answer ack");
        chk(ara_data, 8'h96, "answer byte");
        @(negedge clk);
        ara_req = 1'b0;
        // R7: released after answer and stays released
        cur_req = "R7";
        at_edge(1);
        chk({7'd0, irq_pull_low}, 8'd0, "released after answer");
        nedges(5);
        chk({7'd0, irq_pull_low}, 8'd0, "stays released");
        // R7: a new pin re-raises
        @(negedge clk);
        pin_lvl[33] = ~pin_lvl[33];
        nedges(4);
        chk({7'd0, irq_pull_low}, 8'd1, "new pin re-raises");
        bank_read(1);
        bank_read(4);
        nedges(3);
        chk({7'd0, irq_pull_low}, 8'd0, "all cleared");

        // R1: several pins at once in bank 3 under another pattern
        cur_req = "R1";
        @(negedge clk);
        pin_lvl[31:24] = ~pin_lvl[31:24];
        nedges(4);
        chk({7'd0, irq_pull_low}, 8'd1, "bank-wide change");
        bank_read(3);
        nedges(3);

        compare_on = 1'b0;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule